// File: doc/BRIEF.md
# Watermark Signature Store Unit

This unit sits beside the decode stage and data-memory write port of an 8-bit processor. It adds four instructions, taken from unused opcodes behind the 0xED prefix, that copy a hidden 128-bit signature into data memory. The signature is fixed when the design is built, through a parameter. When software runs the four instructions in order with HL pointing at a buffer, the full watermark appears in memory. Each instruction writes four bytes at the address in HL, moves HL up by one after each byte, and gives the updated pointer back to the core.

The core presents a decoded prefix and opcode together with the current HL value. The unit then holds the memory write port until four ready handshakes have taken place. After that it pulses a completion strobe, and the core uses that strobe to load the new HL value. Any opcode outside the four added codes does nothing in this unit.

Top module: `sig_store_unit`

## Requirements
- R1: While reset is asserted and after it is released, `mem_we_o`, `busy_o`, `done_o` and `hl_we_o` are low.
- R2: When the unit is idle and sees `op_valid_i` high with prefix 0xED and opcode 0x20, 0x21, 0x22 or 0x23 at a clock edge, it raises `busy_o` and `mem_we_o` in the next cycle.
- R3: The signature is divided into sixteen bytes numbered 1 to 16. Byte 1 is the most significant byte of the 128-bit parameter. Opcode 0x20+n writes bytes 4n+1 to 4n+4, in ascending order.
- R4: The k-th byte of an instruction (k = 0..3) is written to address HL+k, where HL is the value captured when the instruction was accepted.
- R5: A byte counts as written only at a clock edge where both `mem_we_o` and `mem_rdy_i` are high. Until then, address and data stay unchanged.
- R6: In the cycle after the fourth handshake, `done_o` and `hl_we_o` are high for exactly one cycle, `busy_o` and `mem_we_o` are low, and `hl_o` equals the captured HL plus 4.
- R7: Opcodes 0x00–0x1F and 0x24–0xFF behind prefix 0xED, and any opcode behind a different prefix, cause no memory write and no `done_o` pulse.
- R8: HL increments wrap modulo 2^16, so 0xFFFF is followed by 0x0000.
- R9: An opcode presented while `busy_o` is high is ignored. The running sequence keeps its address, its byte order and its byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Decoded prefixed opcode valid |
| op_prefix_i | input | 8 | Prefix byte of the decoded instruction |
| op_code_i | input | 8 | Opcode byte following the prefix |
| hl_i | input | 16 | Current HL pointer |
| mem_rdy_i | input | 1 | Memory accepts the write this cycle |
| mem_addr_o | output | 16 | Write address |
| mem_wdata_o | output | 8 | Signature byte to write |
| mem_we_o | output | 1 | Write request |
| hl_o | output | 16 | Updated HL pointer |
| hl_we_o | output | 1 | Load strobe for HL |
| busy_o | output | 1 | Four-byte sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two situations are the hardest to produce. The first is a new valid opcode arriving while the memory is stalling a sequence partway through. The second is a sequence whose pointer crosses 0xFFFF. For the first, the bench drives a pseudo-random ready pattern and issues a second opcode, with a different HL, two cycles after the first one. It then confirms that nothing was written at the second HL and that only one completion pulse occurred. For the second, it starts an instruction at HL 0xFFFE and checks the bytes written on each side of the wrap, as well as the HL value returned.

// File: rtl/sig_store_pkg.sv
package sig_store_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sig_op_decode.sv
module sig_op_decode #(
  parameter logic [7:0] PREFIX  = 8'hED,
  parameter logic [7:0] OP_BASE = 8'h20,
  parameter int         NUM_OPS = 4,
  localparam int        GRP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic             valid_i,
  input  logic [7:0]       prefix_i,
  input  logic [7:0]       code_i,
  output logic             hit_o,
  output logic [GRP_W-1:0] grp_o
);
  logic [8:0] offset;

  assign offset = {1'b0, code_i} - {1'b0, OP_BASE};
  // underflow sets bit 8, so one compare covers both range edges
  assign hit_o  = valid_i && (prefix_i == PREFIX) && (offset < 9'(NUM_OPS));
  assign grp_o  = offset[GRP_W-1:0];
endmodule

// File: rtl/sig_byte_sel.sv
module sig_byte_sel #(
  parameter int  DATA_W  = 8,
  parameter int  NUM_BLK = 16,
  parameter int  SIG_W   = DATA_W * NUM_BLK,
  parameter logic [SIG_W-1:0] SIG = '0,
  localparam int SEL_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] blk [NUM_BLK];

  // block 0 is the most significant byte of the signature
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign blk[g] = SIG[SIG_W-1-g*DATA_W -: DATA_W];
  end

  assign data_o = blk[sel_i];
endmodule

// File: rtl/sig_seq.sv
module sig_seq
  import sig_store_pkg::*;
#(
  parameter int  ADDR_W       = 16,
  parameter int  BYTES_PER_OP = 4,
  parameter int  NUM_OPS      = 4,
  localparam int IDX_W = (BYTES_PER_OP > 1) ? $clog2(BYTES_PER_OP) : 1,
  localparam int GRP_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
  localparam int SEL_W = (BYTES_PER_OP*NUM_OPS > 1) ? $clog2(BYTES_PER_OP*NUM_OPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              mem_rdy_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              ptr_we_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [GRP_W-1:0]  grp_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q;
  logic              accept, step, last_byte;

  assign accept    = hit_i && (state_q == SEQ_IDLE);
  assign step      = (state_q == SEQ_RUN) && mem_rdy_i;
  assign last_byte = (idx_q == IDX_W'(BYTES_PER_OP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ptr_q   <= '0;
      grp_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= SEQ_RUN;
        ptr_q   <= ptr_i;
        grp_q   <= grp_i;
        idx_q   <= '0;
      end else if (step) begin
        ptr_q <= ptr_q + 1'b1; // wraps at 2^ADDR_W
        if (last_byte) begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign mem_we_o   = (state_q == SEQ_RUN);
  assign mem_addr_o = ptr_q;
  assign sel_o      = SEL_W'(grp_q) * SEL_W'(BYTES_PER_OP) + SEL_W'(idx_q);
  assign ptr_o      = ptr_q;
  assign ptr_we_o   = done_q;
  assign busy_o     = (state_q == SEQ_RUN);
  assign done_o     = done_q;

  a_r5_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !mem_rdy_i |=> mem_we_o && $stable(mem_addr_o) && $stable(sel_o));

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_rdy_i |=> done_o || (mem_addr_o == $past(mem_addr_o) + 1'b1));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_we_o && ptr_we_o);

  a_r7_quiet_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !hit_i |=> !mem_we_o);

  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && hit_i && !mem_rdy_i |=> $stable(mem_addr_o) && $stable(sel_o));
endmodule

// File: rtl/sig_store_unit.sv
module sig_store_unit #(
  parameter int         ADDR_W       = 16,
  parameter int         DATA_W       = 8,
  parameter int         BYTES_PER_OP = 4,
  parameter int         NUM_OPS      = 4,
  parameter logic [7:0] PREFIX       = 8'hED,
  parameter logic [7:0] OP_BASE      = 8'h20,
  parameter int         SIG_W        = DATA_W * BYTES_PER_OP * NUM_OPS,
  parameter logic [SIG_W-1:0] SIG    = 128'hC2DA0F795D03238FBD72AB3051000F81
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        op_prefix_i,
  input  logic [7:0]        op_code_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic              mem_rdy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] hl_o,
  output logic              hl_we_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int NUM_BLK = BYTES_PER_OP * NUM_OPS;
  localparam int GRP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;
  localparam int SEL_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  logic             hit;
  logic [GRP_W-1:0] grp;
  logic [SEL_W-1:0] sel;

  sig_op_decode #(
    .PREFIX (PREFIX),
    .OP_BASE(OP_BASE),
    .NUM_OPS(NUM_OPS)
  ) u_decode (
    .valid_i (op_valid_i),
    .prefix_i(op_prefix_i),
    .code_i  (op_code_i),
    .hit_o   (hit),
    .grp_o   (grp)
  );

  sig_seq #(
    .ADDR_W      (ADDR_W),
    .BYTES_PER_OP(BYTES_PER_OP),
    .NUM_OPS     (NUM_OPS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .grp_i     (grp),
    .ptr_i     (hl_i),
    .mem_rdy_i (mem_rdy_i),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .sel_o     (sel),
    .ptr_o     (hl_o),
    .ptr_we_o  (hl_we_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  sig_byte_sel #(
    .DATA_W (DATA_W),
    .NUM_BLK(NUM_BLK),
    .SIG_W  (SIG_W),
    .SIG    (SIG)
  ) u_sel (
    .sel_i (sel),
    .data_o(mem_wdata_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> !mem_we_o && !done_o && !hl_we_o);

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && hit |=> busy_o && mem_we_o && (mem_addr_o == $past(hl_i)));
endmodule

// File: tb/sig_store_unit_tb.sv
module sig_store_unit_tb;
  localparam logic [127:0] SIG_HEX = 128'hC2DA0F795D03238FBD72AB3051000F81;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_prefix = 8'h00;
  logic [7:0]  op_code = 8'h00;
  logic [15:0] hl = 16'h0000;
  logic        rdy = 1'b1;
  logic [15:0] mem_addr, hl_out;
  logic [7:0]  mem_wdata;
  logic        mem_we, hl_we, busy, done;

  int total = 0;
  int fails = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [7:0] mem [int];

  // reference model state
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_grp = 0;
  int          m_idx = 0;
  logic [15:0] m_ptr = 16'h0;

  always #10 clk = ~clk;

  sig_store_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_prefix_i(op_prefix),
    .op_code_i(op_code), .hl_i(hl), .mem_rdy_i(rdy), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .hl_o(hl_out), .hl_we_o(hl_we),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] sig_byte(int k);
    logic [127:0] s;
    s = SIG_HEX >> (8 * (15 - k));
    return s[7:0];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    rdy = stall_en ? lfsr[0] : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0;
      m_done = 1'b0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_done = 1'b0;
      if (!was_busy && op_valid && op_prefix == 8'hED &&
          op_code >= 8'h20 && op_code <= 8'h23) begin
        m_busy = 1'b1;
        m_ptr  = hl;
        m_grp  = int'(op_code) - 32;
        m_idx  = 0;
      end else if (was_busy && rdy) begin
        m_ptr = m_ptr + 16'd1;
        if (m_idx == 3) begin
          m_busy = 1'b0;
          m_done = 1'b1;
        end else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_we == m_busy, "R2 we", int'(mem_we), int'(m_busy));
      chk(busy == m_busy, "R9 busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R6 done", int'(done), int'(m_done));
      chk(hl_we == m_done, "R6 hl_we", int'(hl_we), int'(m_done));
      if (m_busy) begin
        chk(mem_addr == m_ptr, "R4 addr", int'(mem_addr), int'(m_ptr));
        chk(mem_wdata == sig_byte(m_grp*4 + m_idx), "R3 data",
            int'(mem_wdata), int'(sig_byte(m_grp*4 + m_idx)));
      end
      if (m_done) chk(hl_out == m_ptr, "R8 hl_out", int'(hl_out), int'(m_ptr));
      if (mem_we && rdy) begin
        mem[int'(mem_addr)] = mem_wdata;
        wr_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic issue(logic [7:0] pfx, logic [7:0] code, logic [15:0] ptr);
    @(posedge clk); #2;
    op_valid = 1'b1; op_prefix = pfx; op_code = code; hl = ptr;
    @(posedge clk); #2;
    op_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy && !done) break;
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog R6 act=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int d0, w0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_we && !busy && !done && !hl_we, "R1 reset", int'({mem_we, busy, done, hl_we}), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_we && !busy && !done, "R1 after release", int'({mem_we, busy, done}), 0);

    // R3 R4: first instruction at 0x0100, memory always ready
    issue(8'hED, 8'h20, 16'h0100);
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk(mem.exists(32'h100 + k) && mem[32'h100 + k] == sig_byte(k), "R3 block order",
          mem.exists(32'h100 + k) ? int'(mem[32'h100 + k]) : -1, int'(sig_byte(k)));
    chk(mem[32'h100] == 8'hC2 && mem[32'h101] == 8'hDA, "R3 leading bytes",
        int'({mem[32'h100], mem[32'h101]}), 16'hC2DA);

    // R5: remaining instructions with a stalling memory
    stall_en = 1'b1;
    issue(8'hED, 8'h21, 16'h0104); wait_idle();
    issue(8'hED, 8'h22, 16'h0108); wait_idle();
    issue(8'hED, 8'h23, 16'h010C); wait_idle();
    for (int k = 0; k < 16; k++)
      chk(mem[32'h100 + k] == sig_byte(k), "R5 stalled full signature",
          int'(mem[32'h100 + k]), int'(sig_byte(k)));
    chk(done_cnt == 4, "R6 done count", done_cnt, 4);

    // R7: non-matching opcodes
    w0 = wr_cnt; d0 = done_cnt;
    issue(8'hED, 8'h24, 16'h0400);
    issue(8'hED, 8'h1F, 16'h0400);
    issue(8'hDD, 8'h21, 16'h0400);
    issue(8'hFD, 8'h20, 16'h0400);
    repeat (6) @(negedge clk);
    chk(wr_cnt == w0, "R7 no write", wr_cnt - w0, 0);
    chk(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
    chk(!mem.exists(32'h400), "R7 memory untouched", 1, 0);

    // R9: second opcode while busy
    w0 = wr_cnt; d0 = done_cnt;
    fork
      issue(8'hED, 8'h20, 16'h0200);
      begin
        repeat (3) @(posedge clk);
        #2;
        op_valid = 1'b1; op_prefix = 8'hED; op_code = 8'h23; hl = 16'h0300;
        @(posedge clk); #2;
        op_valid = 1'b0;
      end
    join
    wait_idle();
    chk(!mem.exists(32'h300), "R9 ignored while busy", 1, 0);
    chk(wr_cnt - w0 == 4, "R9 byte count", wr_cnt - w0, 4);
    chk(done_cnt - d0 == 1, "R9 single done", done_cnt - d0, 1);
    chk(mem[32'h203] == sig_byte(3), "R9 order kept", int'(mem[32'h203]), int'(sig_byte(3)));

    // R8: wrap at top of address space
    stall_en = 1'b0;
    issue(8'hED, 8'h22, 16'hFFFE);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) begin
        chk(hl_out == 16'h0002, "R8 wrapped hl", int'(hl_out), 2);
        break;
      end
    end
    wait_idle();
    chk(mem[32'hFFFF] == sig_byte(9), "R8 before wrap", int'(mem[32'hFFFF]), int'(sig_byte(9)));
    chk(mem[32'h0000] == sig_byte(10), "R8 after wrap", int'(mem[32'h0000]), int'(sig_byte(10)));
    chk(mem[32'h0001] == sig_byte(11), "R8 last byte", int'(mem[32'h0001]), int'(sig_byte(11)));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule